// File: doc/BRIEF.md
# Receive Timestamp Insertion and Capture Statistics

This block sits on the receive path of one Ethernet port. Frames arrive on a 64-bit word stream with start and end markers and a valid-byte count on the last word. Each frame is stamped on arrival with the value of a free-running cycle counter. While capture is on, the stamp leaves the block as one extra word ahead of the frame's first data word, marked by a sideband flag. While capture is off, no stamp word is emitted, so the stream passes unchanged and the port behaves as a plain network interface.

The capture setting is taken once per frame, when the frame's first word first appears. A frame is therefore carried whole in one form or the other. Backpressure from the receive FIFO stalls the stream without losing or repeating the stamp word. During a capture run the block keeps three totals: frames received, bytes received and elapsed capture cycles. A one-cycle clear pulse resets all three.

Top module: `rx_stamp_capture`

## Requirements
- R1: The timestamp counter resets to 0 and adds 1 on every clock edge out of reset. A frame's stamp is the counter value in the cycle its start word is first presented. The stamp holds while the stamp word is stalled.
- R2: In capture mode the first output word of a frame is the stamp word: `out_ts`=1, `out_sop`=1, `out_eop`=0, `out_bytes`=8. The frame's data words follow unchanged, with `out_sop`=0 on the first of them and `out_ts`=0 on all of them.
- R3: In pass-through mode each frame leaves exactly as it arrived, with data, start, end and byte count unchanged and `out_ts`=0. No extra word is added.
- R4: The mode is sampled when a frame's start word is first presented. Changing `cap_en` later in the frame changes neither that frame's form nor whether it is counted.
- R5: A low `out_ready` stalls the stream with no word lost or repeated. `in_ready` is 0 while the stamp word is on the output.
- R6: `pkt_count` adds 1 when the end word of a capture-mode frame is accepted. Pass-through frames are not counted.
- R7: For capture-mode frames, `byte_count` adds 8 for each accepted data word that is not an end word, and adds `in_bytes` (1 to 8) for the end word. Stamp words are not counted.
- R8: `cap_time` adds 1 on every clock edge at which `cap_en` is 1. It holds its value while `cap_en` is 0.
- R9: A `stats_clr` pulse sets all three counters to 0 on that edge, taking priority over any increment.
- R10: Reset clears all three counters and the timestamp counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable |
| stats_clr | input | 1 | One-cycle clear of the statistics counters |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 64 | Input data word |
| in_sop | input | 1 | First word of a frame |
| in_eop | input | 1 | Last word of a frame |
| in_bytes | input | 4 | Valid bytes in the last word (1 to 8) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 64 | Output data word or stamp |
| out_sop | output | 1 | First output word of a frame |
| out_eop | output | 1 | Last output word of a frame |
| out_bytes | output | 4 | Valid bytes of the output word |
| out_ts | output | 1 | Output word is a timestamp |
| pkt_count | output | 32 | Frames counted in capture mode |
| byte_count | output | 48 | Bytes counted in capture mode |
| cap_time | output | 48 | Cycles with capture enabled |

## Verification
The assertions check on every cycle that a stalled stamp word stays on the output, that exactly one stamp word is accepted per frame, that the frame count steps by at most one and the byte count by at most eight, that the capture timer runs or holds as `cap_en` dictates, and that a clear empties all counters. Only the bench's scenarios can show that each stamp equals the arrival cycle and that every frame length and end-byte count is carried unchanged in both modes under three stall patterns. The same scenarios show that a mode change within a frame is ignored and that the running totals match the arithmetic sums of the frames sent.

// File: rtl/rx_stamp_capture.sv
module rx_stamp_capture #(
  parameter int DW     = 64,
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 48,
  parameter int TIME_W = 48,
  localparam int BEW   = $clog2(DW/8) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              stats_clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [BEW-1:0]    in_bytes,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [BEW-1:0]    out_bytes,
  output logic              out_ts,
  output logic [CNT_W-1:0]  pkt_count,
  output logic [BYTE_W-1:0] byte_count,
  output logic [TIME_W-1:0] cap_time
);

  logic [DW-1:0] ts_cnt, ts_q;
  logic          lock, mode_q, ts_sent;

  wire           eff_mode = lock ? mode_q : cap_en;
  wire [DW-1:0]  eff_ts   = lock ? ts_q : ts_cnt;
  wire           ins      = in_valid & in_sop & eff_mode & ~ts_sent;
  wire           take     = in_valid & in_ready;
  wire           hit      = take & eff_mode;

  assign in_ready  = out_ready & ~ins;
  assign out_valid = in_valid;
  assign out_ts    = ins;
  assign out_data  = ins ? eff_ts : in_data;
  assign out_sop   = in_sop & (ins | ~eff_mode);
  assign out_eop   = in_eop & ~ins;
  assign out_bytes = ins ? BEW'(DW/8) : in_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_cnt <= '0;
    else        ts_cnt <= ts_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock   <= 1'b0;
      mode_q <= 1'b0;
      ts_q   <= '0;
    end else begin
      if (!lock && in_valid && in_sop) begin
        mode_q <= cap_en;
        ts_q   <= ts_cnt;
      end
      if (take && in_eop)               lock <= 1'b0;
      else if (in_valid && in_sop)      lock <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ts_sent <= 1'b0;
    else if (take && in_sop)    ts_sent <= 1'b0;
    else if (ins && out_ready)  ts_sent <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_count  <= '0;
      byte_count <= '0;
      cap_time   <= '0;
    end else if (stats_clr) begin
      pkt_count  <= '0;
      byte_count <= '0;
      cap_time   <= '0;
    end else begin
      if (hit && in_eop) pkt_count <= pkt_count + 1'b1;
      if (hit)           byte_count <= byte_count + BYTE_W'(in_eop ? in_bytes : BEW'(DW/8));
      if (cap_en)        cap_time <= cap_time + 1'b1;
    end
  end

  AST_TS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ins && !out_ready |=> out_ts && $stable(out_data)); // R5
  AST_ONE_TS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_ts |=> !out_ts); // R2
  AST_PKT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !stats_clr |=> (pkt_count == $past(pkt_count)) || (pkt_count == $past(pkt_count) + 1'b1)); // R6
  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !stats_clr |=> (byte_count >= $past(byte_count)) && (byte_count - $past(byte_count) <= BYTE_W'(8))); // R7
  AST_TIME_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en && !stats_clr |=> cap_time == $past(cap_time) + 1'b1); // R8
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en && !stats_clr |=> $stable(cap_time)); // R8
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stats_clr |=> pkt_count == '0 && byte_count == '0 && cap_time == '0); // R9

endmodule

// File: tb/sim_rx_stamp_capture.sv
`timescale 1ns/1ps
module sim_rx_stamp_capture;
  logic clk = 0, rst_n = 0, cap_en = 0, stats_clr = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, out_ready = 1;
  logic [63:0] in_data = '0;
  logic [3:0]  in_bytes = '0;
  logic in_ready, out_valid, out_sop, out_eop, out_ts;
  logic [63:0] out_data;
  logic [3:0]  out_bytes;
  logic [31:0] pkt_count;
  logic [47:0] byte_count, cap_time;

  rx_stamp_capture u0 (.clk, .rst_n, .cap_en, .stats_clr, .in_valid, .in_ready, .in_data,
    .in_sop, .in_eop, .in_bytes, .out_valid, .out_ready, .out_data, .out_sop, .out_eop,
    .out_bytes, .out_ts, .pkt_count, .byte_count, .cap_time);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, bp = 0, wr = 0, rd = 0;
  longint exp_pk = 0, exp_by = 0, exp_tm = 0;
  logic [63:0] ex_d [0:4095];
  logic [6:0]  ex_f [0:4095];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial forever begin @(posedge clk); if (rst_n) cyc <= cyc + 1; end
  initial forever begin
    @(posedge clk);
    if (rst_n) begin
      if (stats_clr) exp_tm <= 0;
      else if (cap_en) exp_tm <= exp_tm + 1;
    end
  end
  initial forever begin
    @(posedge clk); #1;
    out_ready = (bp == 0) ? 1'b1 : (bp == 1) ? cyc[0] : ((cyc % 3) == 0);
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid) begin
      if (out_ts) chk(!in_ready, "R5 in_ready during stamp", in_ready, 0);
      if (out_ready) begin
        if (rd >= wr) chk(0, "R3 extra output word", out_data, 0);
        else begin
          chk(out_data == ex_d[rd], ex_f[rd][6] ? "R1 stamp value" : "R3 data word", out_data, ex_d[rd]);
          chk({out_ts, out_sop, out_eop, out_bytes} == ex_f[rd], "R2 flags ts/sop/eop/bytes",
              {out_ts, out_sop, out_eop, out_bytes}, ex_f[rd]);
          rd++;
        end
      end
    end
  end

  task automatic push(input logic [63:0] d, input logic [6:0] f);
    ex_d[wr] = d; ex_f[wr] = f; wr++;
  endtask

  task automatic send_pkt(input int pid, input int n, input int lb, input int flip);
    bit m; bit ok;
    @(posedge clk); #1;
    m = cap_en;
    if (m) push(64'(cyc), {1'b1, 1'b1, 1'b0, 4'd8});
    for (int b = 0; b < n; b++)
      push({16'hA5A5, 16'(pid), 16'h0, 16'(b)},
           {1'b0, (b == 0) && !m, b == n-1, (b == n-1) ? 4'(lb) : 4'd8});
    if (m) begin exp_pk++; exp_by += (n-1)*8 + lb; end
    for (int b = 0; b < n; b++) begin
      in_valid = 1; in_data = {16'hA5A5, 16'(pid), 16'h0, 16'(b)};
      in_sop = (b == 0); in_eop = (b == n-1); in_bytes = (b == n-1) ? 4'(lb) : 4'd8;
      if (b == flip) cap_en = ~cap_en;
      ok = 0;
      while (!ok) begin
        @(negedge clk); ok = in_ready;
        @(posedge clk); #1;
      end
    end
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic drain_and_check(input string tag);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(rd == wr, "R5 all words delivered", rd, wr);
    chk(pkt_count == 32'(exp_pk), "R6 packet total", pkt_count, exp_pk);
    chk(byte_count == 48'(exp_by), "R7 byte total", byte_count, exp_by);
    chk(cap_time == 48'(exp_tm), "R8 capture time", cap_time, exp_tm);
    if (tag.len() == 0) ;
  endtask

  task automatic pulse_clear();
    @(posedge clk); #1; stats_clr = 1; exp_pk = 0; exp_by = 0;
    @(posedge clk); #1; stats_clr = 0;
    @(negedge clk);
    chk(pkt_count == 0 && byte_count == 0, "R9 clear counts", pkt_count + byte_count, 0);
    chk(cap_time == 48'(exp_tm), "R9 clear time", cap_time, exp_tm);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int pid = 0;
    repeat (3) @(negedge clk);
    chk(pkt_count == 0 && byte_count == 0 && cap_time == 0, "R10 reset counters",
        pkt_count + byte_count + cap_time, 0);
    @(posedge clk); #1; rst_n = 1;
    repeat (3) @(posedge clk);
    for (int m = 0; m < 2; m++) begin
      @(posedge clk); #1; cap_en = m[0];
      for (int p = 0; p < 3; p++) begin
        bp = p;
        for (int n = 1; n <= 4; n++)
          for (int lb = 1; lb <= 8; lb++) begin send_pkt(pid, n, lb, -1); pid++; end
        drain_and_check("sweep");
      end
    end
    pulse_clear();
    drain_and_check("after clear");
    for (int p = 0; p < 3; p++) begin
      bp = p;
      for (int n = 2; n <= 5; n++) begin
        @(posedge clk); #1; cap_en = 1;
        send_pkt(pid, n, 3, 1); pid++;
        @(posedge clk); #1; cap_en = 0;
        send_pkt(pid, n, 5, n-1); pid++;
      end
      drain_and_check("R4 mid-frame toggle");
    end
    @(posedge clk); #1; cap_en = 0;
    repeat (20) @(posedge clk);
    drain_and_check("R8 hold");
    @(posedge clk); #1; cap_en = 1;
    repeat (7) @(posedge clk);
    pulse_clear();
    drain_and_check("R9 priority");
    finish_run();
  end
endmodule